// File: doc/BRIEF.md
# Two-Wire Slave Register Bank

This block lets a host reach the nine byte-wide registers of a light-sensor front end over a two-wire SMBus/I2C-compatible bus. It watches SCL and SDA through synchronisers and finds START and STOP conditions. It compares the 7-bit address in the first byte with an address taken from a strap input, and acknowledges only when the two agree. After the address it serves the six standard transfers: Send Byte, Write Byte, Write Word, Receive Byte, Read Byte and Read Word. SDA is open-drain and is modelled as an input plus an output enable; when `sda_oe` is 1 the line is pulled low.

Registers 0 to 5 can be read and written from the bus, and the chip sees them on `rw_regs_o`. Registers 6, 7 and 8 are read-only from the bus. Internal logic loads them through a valid/ready port. `ro_ready` is held at 1, so there is never back-pressure: every cycle in which `ro_valid` is high, `ro_data` is written into the register that `ro_sel` picks. Register 0 bit 6 is the enable bit, and a 0-to-1 change of this bit reloads the strap.

Top module: `smb_regbank`

## Requirements
- R1: The strap code selects the 7-bit address. 00 (open) and 11 give 0010000 (20h), 01 (ground) gives 0010001 (22h), and 10 (supply) gives 0111000 (70h). The strap is sampled after reset and again when a bus write takes register 0 bit 6 from 0 to 1. A strap change at any other time has no effect.
- R2: An address byte that does not match is not acknowledged, and SDA stays released until the next START.
- R3: A matching address byte is acknowledged. Its last bit selects the direction, 0 for write and 1 for read.
- R4: The first byte after a write address is the command. A value below 9 is ACKed and becomes the register pointer. A value of 9 or more is NACKed. A Send Byte is the command byte alone.
- R5: Each data byte of a write goes to the register at the pointer, and the pointer then advances by one. A Write Word therefore fills cmd and then cmd+1. A data byte is ACKed only while the pointer is below 9.
- R6: Registers 6, 7 and 8 hold their value when the bus writes to them, although the byte is still ACKed. Only the internal port changes them: `ro_sel` 0, 1 and 2 map to registers 6, 7 and 8, and `ro_ready` is always 1.
- R7: A read that has had no command byte since the last STOP (Receive Byte) returns register 0.
- R8: A read after a command and a repeated START returns the register at cmd. Each master ACK advances to the next register. Any pointer at 9 or beyond reads 00h.
- R9: Register 0 bit 7 is reserved and always reads 0. After reset register 0 holds 40h and every other register holds 00h.
- R10: The slave changes `sda_oe` only while SCL is low, except that START and STOP release it. It samples SDA on the rising edge of SCL.
- R11: `rw_regs_o` carries register i in bits 8i+7 down to 8i, for i from 0 to 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe | output | 1 | 1 pulls SDA low |
| strap_i | input | 2 | Address strap code |
| ro_valid | input | 1 | Internal update of a read-only register |
| ro_sel | input | 2 | Read-only register select (0 to 2) |
| ro_data | input | 8 | Value for the read-only register |
| ro_ready | output | 1 | Always 1 |
| rw_regs_o | output | 48 | Contents of registers 0 to 5 |

## Verification
The bench aims at the places where the pointer has to stop or wrap. A Read Word that starts at register 8 must return 00h for its second byte; a design that wraps the pointer or indexes past the end would return a stale or random byte there. A bus write to read-only register 7 must be ACKed and then read back unchanged; a missing write guard would overwrite the value. The bench also changes the strap without a re-enable, then performs a disable and re-enable and checks the new address. A design that samples the strap all the time would move its address early. A Receive Byte is sent after a command pointer has been left elsewhere, and a design that ignores the STOP would return the wrong register.

// File: rtl/smb_pkg.sv
package smb_pkg;
  typedef enum logic [2:0] {
    L_IDLE, L_ADDR, L_WBYTE, L_ACK, L_RBYTE, L_MACK
  } link_st_t;

  function automatic logic [6:0] strap_addr(input logic [1:0] code);
    case (code)
      2'b01:   return 7'b0010001;
      2'b10:   return 7'b0111000;
      default: return 7'b0010000;
    endcase
  endfunction

  function automatic logic [7:0] wr_mask(input int idx);
    return (idx == 0) ? 8'h7F : 8'hFF;
  endfunction
endpackage

// File: rtl/smb_line_sync.sv
module smb_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '1;
    else        chain <= {chain[STAGES-2:0], d};
  end
  assign q = chain[STAGES-1];
endmodule

// File: rtl/smb_regfile.sv
module smb_regfile
  import smb_pkg::*;
#(
  parameter int NRW = 6,
  parameter int NRO = 3,
  parameter int PW  = 5,
  localparam int NREG = NRW + NRO,
  localparam int SW = (NRO > 1) ? $clog2(NRO) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_we,
  input  logic [PW-1:0]   bus_addr,
  input  logic [7:0]      bus_wdata,
  output logic [7:0]      bus_rdata,
  output logic            reen,
  input  logic            ro_valid,
  input  logic [SW-1:0]   ro_sel,
  input  logic [7:0]      ro_data,
  output logic [NRW*8-1:0] rw_flat
);
  logic [NRW-1:0][7:0] rw_bank;
  logic [NRO-1:0][7:0] ro_bank;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rw_bank <= '0;
      rw_bank[0] <= 8'h40;
    end else if (bus_we) begin
      for (int i = 0; i < NRW; i++)
        if (bus_addr == PW'(i)) rw_bank[i] <= bus_wdata & wr_mask(i);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ro_bank <= '0;
    else if (ro_valid) begin
      for (int i = 0; i < NRO; i++)
        if (ro_sel == SW'(i)) ro_bank[i] <= ro_data;
    end
  end

  assign reen = bus_we && (bus_addr == '0) && bus_wdata[6] && !rw_bank[0][6];

  always_comb begin
    bus_rdata = 8'h00;
    for (int i = 0; i < NRW; i++)
      if (bus_addr == PW'(i)) bus_rdata = rw_bank[i];
    for (int i = 0; i < NRO; i++)
      if (bus_addr == PW'(NRW + i)) bus_rdata = ro_bank[i];
  end

  assign rw_flat = rw_bank;

  // Bus traffic never disturbs the internally owned bank.
  assert_ro_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !ro_valid |=> $stable(ro_bank));
  // Reserved bit of register 0.
  assert_reserved_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !rw_bank[0][7]);
endmodule

// File: rtl/smb_link.sv
module smb_link
  import smb_pkg::*;
#(
  parameter int NREG = 9,
  parameter int PW   = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_s,
  input  logic          sda_s,
  input  logic [1:0]    strap_i,
  input  logic          reen,
  output logic          sda_oe,
  output logic          bus_we,
  output logic [PW-1:0] ptr,
  output logic [7:0]    wdata,
  input  logic [7:0]    rdata
);
  localparam logic [PW-1:0] LIMIT = PW'(NREG);

  link_st_t   st;
  logic       scl_q, sda_q;
  logic [3:0] bitcnt;
  logic [7:0] shreg, txbuf;
  logic       is_read, expect_cmd, cmd_valid, ack_go, load_pend;
  logic [6:0] my_addr;

  wire scl_rise = scl_s & ~scl_q;
  wire scl_fall = ~scl_s & scl_q;
  wire start_d  = scl_s & scl_q & sda_q & ~sda_s;
  wire stop_d   = scl_s & scl_q & ~sda_q & sda_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1; sda_q <= 1'b1;
      my_addr <= 7'b0010000; load_pend <= 1'b1;
    end else begin
      scl_q <= scl_s; sda_q <= sda_s;
      if (load_pend || reen) my_addr <= strap_addr(strap_i);
      load_pend <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= L_IDLE; bitcnt <= '0; shreg <= '0; txbuf <= '0;
      is_read <= 1'b0; expect_cmd <= 1'b0; cmd_valid <= 1'b0;
      ack_go <= 1'b0; sda_oe <= 1'b0; ptr <= '0; bus_we <= 1'b0;
    end else begin
      bus_we <= 1'b0;
      if (stop_d) begin
        st <= L_IDLE; sda_oe <= 1'b0; cmd_valid <= 1'b0;
      end else if (start_d) begin
        st <= L_ADDR; sda_oe <= 1'b0; bitcnt <= '0; expect_cmd <= 1'b1;
      end else if (scl_rise) begin
        if ((st == L_ADDR || st == L_WBYTE) && bitcnt < 4'd8) begin
          shreg  <= {shreg[6:0], sda_s};
          bitcnt <= bitcnt + 4'd1;
        end else if (st == L_MACK) begin
          ack_go <= ~sda_s;
          if (ptr < LIMIT) ptr <= ptr + 1'b1;
        end
      end else if (scl_fall) begin
        unique case (st)
          L_ADDR: if (bitcnt == 4'd8) begin
            if (shreg[7:1] == my_addr) begin
              is_read <= shreg[0]; ack_go <= 1'b1; sda_oe <= 1'b1; st <= L_ACK;
              if (shreg[0] && !cmd_valid) ptr <= '0;
            end else st <= L_IDLE;
          end
          L_WBYTE: if (bitcnt == 4'd8) begin
            st <= L_ACK;
            expect_cmd <= 1'b0;
            if (expect_cmd) begin
              if (shreg < 8'(NREG)) begin
                ptr <= PW'(shreg); cmd_valid <= 1'b1; ack_go <= 1'b1; sda_oe <= 1'b1;
              end else begin
                ack_go <= 1'b0;
              end
            end else if (ptr < LIMIT) begin
              bus_we <= 1'b1; wdata <= shreg;
              ack_go <= 1'b1; sda_oe <= 1'b1;
            end else begin
              ack_go <= 1'b0;
            end
          end
          L_ACK: begin
            sda_oe <= 1'b0; bitcnt <= '0;
            if (!ack_go) st <= L_IDLE;
            else if (is_read) begin
              sda_oe <= ~rdata[7]; txbuf <= {rdata[6:0], 1'b0};
              bitcnt <= 4'd1; st <= L_RBYTE;
            end else st <= L_WBYTE;
          end
          L_RBYTE: begin
            if (bitcnt < 4'd8) begin
              sda_oe <= ~txbuf[7]; txbuf <= {txbuf[6:0], 1'b0};
              bitcnt <= bitcnt + 4'd1;
            end else begin
              sda_oe <= 1'b0; st <= L_MACK;
            end
          end
          L_MACK: begin
            if (ack_go) begin
              sda_oe <= ~rdata[7]; txbuf <= {rdata[6:0], 1'b0};
              bitcnt <= 4'd1; st <= L_RBYTE;
            end else st <= L_IDLE;
          end
          default: ;
        endcase
      end
      // Data write lands one cycle after the decision, then the pointer moves.
      if (bus_we && ptr < LIMIT) ptr <= ptr + 1'b1;
    end
  end

  // The pull-down only starts while the clock line is low.
  assert_sda_low_phase_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_s);
  // An unaddressed slave never touches the data line.
  assert_idle_released_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == L_IDLE) |-> !sda_oe);
  // The pointer never runs past one beyond the last register.
  assert_ptr_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ptr <= LIMIT);
endmodule

// File: rtl/smb_regbank.sv
module smb_regbank #(
  parameter int NRW    = 6,
  parameter int NRO    = 3,
  parameter int STAGES = 2,
  localparam int NREG  = NRW + NRO,
  localparam int PW    = $clog2(NREG) + 1,
  localparam int SW    = (NRO > 1) ? $clog2(NRO) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             sda_oe,
  input  logic [1:0]       strap_i,
  input  logic             ro_valid,
  input  logic [SW-1:0]    ro_sel,
  input  logic [7:0]       ro_data,
  output logic             ro_ready,
  output logic [NRW*8-1:0] rw_regs_o
);
  logic scl_s, sda_s, bus_we, reen;
  logic [PW-1:0] ptr;
  logic [7:0] wdata, rdata;

  smb_line_sync #(.STAGES(STAGES)) u_scl_sync (.clk(clk), .rst_n(rst_n), .d(scl_i), .q(scl_s));
  smb_line_sync #(.STAGES(STAGES)) u_sda_sync (.clk(clk), .rst_n(rst_n), .d(sda_i), .q(sda_s));

  smb_link #(.NREG(NREG), .PW(PW)) u_link (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s), .strap_i(strap_i),
    .reen(reen), .sda_oe(sda_oe), .bus_we(bus_we), .ptr(ptr), .wdata(wdata), .rdata(rdata));

  smb_regfile #(.NRW(NRW), .NRO(NRO), .PW(PW)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(ptr), .bus_wdata(wdata),
    .bus_rdata(rdata), .reen(reen), .ro_valid(ro_valid), .ro_sel(ro_sel),
    .ro_data(ro_data), .rw_flat(rw_regs_o));

  assign ro_ready = 1'b1;
endmodule

// File: tb/smb_regbank_tb.sv
module smb_regbank_tb;
  localparam int CLK_P = 10;
  localparam int HP = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic [1:0] strap = 2'b00;
  logic ro_valid = 1'b0;
  logic [1:0] ro_sel = '0;
  logic [7:0] ro_data = '0;
  logic sda_oe, ro_ready;
  logic [47:0] rw_regs;
  wire sda_line = sda_m & ~sda_oe;

  int n_chk = 0, n_bad = 0, hi_changes = 0;
  bit done = 0;

  typedef struct { string req; int val; } item_t;
  item_t exp_q[$];

  always #(CLK_P/2) clk = ~clk;

  smb_regbank u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
    .strap_i(strap), .ro_valid(ro_valid), .ro_sel(ro_sel), .ro_data(ro_data),
    .ro_ready(ro_ready), .rw_regs_o(rw_regs));

  // Monitor side of the scoreboard: every observation pops one expectation.
  task automatic observe(input int act);
    item_t e;
    if (exp_q.size() == 0) begin
      n_chk++; n_bad++;
      $display("FAIL scoreboard empty, actual %0h expected none", act);
      return;
    end
    e = exp_q.pop_front();
    n_chk++;
    if (act !== e.val) begin
      n_bad++;
      $display("FAIL %s actual %0h expected %0h", e.req, act, e.val);
    end
  endtask

  task automatic expect_item(input string req, input int val);
    exp_q.push_back('{req, val});
  endtask

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic hclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  // R10: slave pull-down must not move while the clock line is high.
  logic oe_q = 1'b0;
  always @(negedge clk) begin
    if (rst_n && sda_oe !== oe_q && scl_m) hi_changes++;
    oe_q = sda_oe;
  end

  task automatic bus_start();
    sda_m = 1; hclk(HP); scl_m = 1; hclk(HP); sda_m = 0; hclk(HP); scl_m = 0; hclk(2);
  endtask

  task automatic bus_stop();
    sda_m = 0; hclk(HP); scl_m = 1; hclk(HP); sda_m = 1; hclk(HP);
  endtask

  // Driver: send a byte; ACK level expected (0 = ACK, 1 = NACK) goes to the queue.
  task automatic wb(input logic [7:0] b, input int exp_nack, input string req);
    expect_item(req, exp_nack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; hclk(HP); scl_m = 1; hclk(HP); scl_m = 0; hclk(2);
    end
    sda_m = 1; hclk(HP); scl_m = 1; hclk(HP/2);
    observe(int'(sda_line));
    hclk(HP/2); scl_m = 0; hclk(2);
  endtask

  task automatic rb(input logic mnack, input int exp_val, input string req);
    logic [7:0] v;
    expect_item(req, exp_val);
    sda_m = 1;
    for (int i = 7; i >= 0; i--) begin
      hclk(HP); scl_m = 1; hclk(HP/2); v[i] = sda_line; hclk(HP/2); scl_m = 0; hclk(2);
    end
    observe(int'(v));
    sda_m = mnack; hclk(HP); scl_m = 1; hclk(HP); scl_m = 0; hclk(2); sda_m = 1;
  endtask

  task automatic wr_reg(input logic [6:0] a, input logic [7:0] cmd, input logic [7:0] d, input string req);
    bus_start(); wb({a, 1'b0}, 0, req); wb(cmd, 0, req); wb(d, 0, req); bus_stop();
  endtask

  initial begin
    hclk(5); rst_n = 1; hclk(5);
    check("R9 reset value", int'(rw_regs), 48'h40);
    check("R10 reset release", int'(sda_oe), 0);
    check("R6 ready", int'(ro_ready), 1);

    // R2 wrong address: NACK, then line stays released
    bus_start(); wb({7'h11, 1'b0}, 1, "R2 addr nack"); wb(8'h00, 1, "R2 ignored"); bus_stop();

    // R3/R5 write byte and word
    wr_reg(7'h10, 8'd1, 8'hA5, "R3 write byte");
    check("R5 reg1", int'(rw_regs[15:8]), 8'hA5);
    bus_start(); wb({7'h10, 1'b0}, 0, "R5 word addr"); wb(8'd2, 0, "R5 cmd");
    wb(8'h3C, 0, "R5 lo"); wb(8'hC3, 0, "R5 hi"); bus_stop();
    check("R11 regs 2,3", int'(rw_regs[31:16]), 16'hC33C);

    // R9 reserved bit
    wr_reg(7'h10, 8'd0, 8'hFF, "R9 write");
    check("R9 reg0", int'(rw_regs[7:0]), 8'h7F);

    // R4 send byte
    bus_start(); wb({7'h10, 1'b0}, 0, "R4 addr"); wb(8'd9, 1, "R4 cmd 9 nack"); bus_stop();
    bus_start(); wb({7'h10, 1'b0}, 0, "R4 addr"); wb(8'd3, 0, "R4 cmd 3 ack"); bus_stop();

    // R6 internal updates, R8 read word
    for (int i = 0; i < 3; i++) begin
      ro_valid = 1; ro_sel = 2'(i); ro_data = 8'(8'h11 * (i + 1)); hclk(1);
    end
    ro_valid = 0; hclk(2);
    bus_start(); wb({7'h10, 1'b0}, 0, "R8 addr"); wb(8'd6, 0, "R8 cmd");
    bus_start(); wb({7'h10, 1'b1}, 0, "R3 read addr");
    rb(0, 8'h11, "R8 word lo"); rb(1, 8'h22, "R8 word hi"); bus_stop();

    wr_reg(7'h10, 8'd7, 8'h99, "R6 write ro acked");
    bus_start(); wb({7'h10, 1'b0}, 0, "R6 addr"); wb(8'd7, 0, "R6 cmd");
    bus_start(); wb({7'h10, 1'b1}, 0, "R6 raddr"); rb(1, 8'h22, "R6 ro unchanged"); bus_stop();

    // R7 receive byte
    bus_start(); wb({7'h10, 1'b1}, 0, "R7 addr"); rb(1, 8'h7F, "R7 reg0"); bus_stop();

    // R8 past the end
    bus_start(); wb({7'h10, 1'b0}, 0, "R8 addr"); wb(8'd8, 0, "R8 cmd8");
    bus_start(); wb({7'h10, 1'b1}, 0, "R8 raddr");
    rb(0, 8'h33, "R8 reg8"); rb(1, 8'h00, "R8 beyond"); bus_stop();

    // R1 strap handling
    strap = 2'b10; hclk(4);
    bus_start(); wb({7'h38, 1'b0}, 1, "R1 no resample"); bus_stop();
    wr_reg(7'h10, 8'd0, 8'h00, "R1 disable");
    check("R1 reg0 cleared", int'(rw_regs[7:0]), 0);
    wr_reg(7'h10, 8'd0, 8'h40, "R1 enable");
    bus_start(); wb({7'h38, 1'b0}, 0, "R1 new addr 70h"); bus_stop();
    bus_start(); wb({7'h10, 1'b0}, 1, "R1 old addr gone"); bus_stop();
    strap = 2'b01;
    wr_reg(7'h38, 8'd0, 8'h00, "R1 disable2");
    wr_reg(7'h38, 8'd0, 8'h40, "R1 enable2");
    bus_start(); wb({7'h11, 1'b0}, 0, "R1 addr 22h"); bus_stop();

    check("R10 sda stable while scl high", hi_changes, 0);
    check("R2 scoreboard drained", exp_q.size(), 0);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired, actual running expected done");
      end
    join_any
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule